// File: doc/BRIEF.md
# Priority-Resolved Pin Function Multiplexer

This block chooses, for each pad in a small bank of multi-function pins, which internal source owns the pad. Every pin carries up to five ranked candidate sources, with level 0 ranked highest, and one fallback source. A level is live when at least one of its enable terms is true. Each term is an AND of field comparisons made against four writable control words and a read-only strap word. The highest live level wins the pin. When no level is live, the fallback wins. The fallback need not be a GPIO: on one pin, GPIO sits at level 0 and a dedicated function is the fallback.

Software writes the control words through a simple word-addressed port with byte enables. The strap word is captured once from the `strap_i` input after reset is released. The block then does three things from its registered state, all in the same cycle. It drives a one-hot selection vector per pin. It routes the winning source's output data and output enable to the pad. It returns the pad input to the winning source and parks every other source at its idle level.

Top module: `pinmux_top`

## Requirements
- R1: After reset, all four control words read 0. The strap word holds the value `strap_i` had a few cycles after reset release. Later changes on `strap_i` have no effect until the next reset.
- R2: The control words sit at byte addresses 0x00, 0x04, 0x08 and 0x0C. A write updates only the bytes whose `be_i` bit is set, and a read returns the stored value. The strap word reads at 0x10 and ignores writes. Any other word address reads 0.
- R3: `sel_o` holds 6 bits per pin. Bit p*6+k selects level k of pin p, and bit p*6+5 selects the fallback. Exactly one bit per pin is set at all times.
- R4: A level is selected only when it is live and no lower-numbered (higher-ranked) level on that pin is live. The fallback is selected only when no level is live.
- R5: Pin 0 level 0 requires ctl0[3]=1 AND ctl1[15]=1 AND ctl2[31]=0. Level 1 requires the same first two bits AND ctl2[31]=1. Clearing any required bit forces the pin to the fallback.
- R6: Pin 1 level 0 is live when ctl1[12]=1 OR strap[14]=1. With strap[14]=1, no register write can remove it.
- R7: Pin 2 level 0 needs the 2-bit mode field ctl2[5:4] nonzero AND ctl3[17]=1. Level 1 needs only ctl3[17]=1.
- R8: Pin 3 level 0 needs ctl2[5:4]=3 exactly AND ctl3[22]=1. Level 1 needs only ctl3[22]=1.
- R9: Pin 4 level 0 (its GPIO) needs ctl3[0]=1. Level 1 needs strap[6]=0. Otherwise the non-GPIO fallback owns the pad.
- R10: `pad_o` and `pad_oe_o` of pin p equal `src_do_i` and `src_oe_i` at the selected bit of pin p, and change in the same cycle as `sel_o`.
- R11: The selected source's `src_di_o` bit returns `pad_i` of its pin. Each unselected source reads its idle value instead. The idle value is 1 for pin 0 levels 0 and 1, pin 1 level 0, and pin 3 level 1. It is 0 for every other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 32 | Strap value captured after reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 5 | Byte address of the word |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| rdata_o | output | 32 | Read data for `addr_i` |
| sel_o | output | 30 | One-hot source selection, 6 bits per pin |
| src_do_i | input | 30 | Output data from each candidate source |
| src_oe_i | input | 30 | Output enable from each candidate source |
| src_di_o | output | 30 | Pad input returned to each source, or its idle value |
| pad_i | input | 5 | Input value from each pad |
| pad_o | output | 5 | Output data to each pad |
| pad_oe_o | output | 5 | Output enable to each pad |

## Verification
The bench targets the cases where ranking and term structure interact. The first is the AND term with a required zero on pin 0: a design that ignores the compare value would select level 0 and level 1 together, or pick the wrong one. The second is the strap OR term on pin 1: a design that lets writes reach the strap would drop that pin to GPIO. Third, the mode field is swept through all four codes on pins 2 and 3, so a design that treats "nonzero" and "equals 3" alike would misplace the 01 and 10 codes. Fourth, the non-GPIO fallback on pin 4 is tested with both strap polarities. Random control words, random source data and several strap values check that pad routing and idle values always follow the selection in the same cycle.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NUM_PINS  = 5;
  localparam int NUM_LVL   = 5;
  localparam int NUM_EXPR  = 2;
  localparam int NUM_DESC  = 3;
  localparam int NUM_CTL   = 4;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int NSRC      = NUM_LVL + 1;
  localparam int NWORD     = NUM_CTL + 1;
  localparam int STRAP_IDX = NUM_CTL;
  localparam int NBYTE     = DATA_W / 8;

  // One field comparison: word index, field lsb, field mask, compare kind, value
  typedef struct packed {
    logic       used;
    logic [2:0] word;
    logic [4:0] lsb;
    logic [1:0] mask;
    logic       neq;
    logic [1:0] val;
  } fdesc_t;

  function automatic fdesc_t mk(int w, int lsb, int msk, int neq, int val);
    fdesc_t r;
    r.used = 1'b1;
    r.word = 3'(w);
    r.lsb  = 5'(lsb);
    r.mask = 2'(msk);
    r.neq  = 1'(neq);
    r.val  = 2'(val);
    return r;
  endfunction

  // Term table of the pin bank: pin p, level l, term e, comparison d
  function automatic fdesc_t desc_at(int p, int l, int e, int d);
    fdesc_t r;
    r = '0;
    case (p)
      0: if (e == 0 && l <= 1) begin
           if (d == 0) r = mk(0, 3, 1, 0, 1);
           if (d == 1) r = mk(1, 15, 1, 0, 1);
           if (d == 2) r = mk(2, 31, 1, 0, l);
         end
      1: if (l == 0 && d == 0) begin
           if (e == 0) r = mk(1, 12, 1, 0, 1);
           if (e == 1) r = mk(STRAP_IDX, 14, 1, 0, 1);
         end
      2: if (e == 0) begin
           if (l == 0 && d == 0) r = mk(2, 4, 3, 1, 0);
           if (l == 0 && d == 1) r = mk(3, 17, 1, 0, 1);
           if (l == 1 && d == 0) r = mk(3, 17, 1, 0, 1);
         end
      3: if (e == 0) begin
           if (l == 0 && d == 0) r = mk(2, 4, 3, 0, 3);
           if (l == 0 && d == 1) r = mk(3, 22, 1, 0, 1);
           if (l == 1 && d == 0) r = mk(3, 22, 1, 0, 1);
         end
      4: if (e == 0 && d == 0) begin
           if (l == 0) r = mk(3, 0, 1, 0, 1);
           if (l == 1) r = mk(STRAP_IDX, 6, 1, 0, 0);
         end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Idle level seen by an unselected source (1 for active-low sources)
  function automatic logic idle_of(int p, int s);
    return ((p == 0) && (s <= 1)) || ((p == 1) && (s == 0)) || ((p == 3) && (s == 1));
  endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DATA_W-1:0]            strap_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [NBYTE-1:0]             be_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NWORD-1:0][DATA_W-1:0] words_o
);
  localparam int CTL_AW = $clog2(NUM_CTL);

  logic [1:0]                        rsync_q;
  logic                              rst_sync_n;
  logic [NUM_CTL-1:0][DATA_W-1:0]    ctl_q, ctl_d;
  logic [DATA_W-1:0]                 strap_q, strap_d;
  logic                              ld_q, ld_d;
  logic                              reg_en;
  logic [ADDR_W-3:0]                 widx;

  // Reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  assign widx   = addr_i[ADDR_W-1:2];
  assign reg_en = wr_en_i || !ld_q;

  always_comb begin
    ctl_d   = ctl_q;
    strap_d = strap_q;
    ld_d    = 1'b1;
    if (!ld_q) strap_d = strap_i;
    if (wr_en_i && (int'(widx) < NUM_CTL)) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (be_i[b]) ctl_d[widx[CTL_AW-1:0]][8*b +: 8] = wdata_i[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q   <= '0;
      strap_q <= '0;
      ld_q    <= 1'b0;
    end else if (reg_en) begin
      ctl_q   <= ctl_d;
      strap_q <= strap_d;
      ld_q    <= ld_d;
    end
  end

  always_comb begin
    if (int'(widx) < NUM_CTL)        rdata_o = ctl_q[widx[CTL_AW-1:0]];
    else if (int'(widx) == STRAP_IDX) rdata_o = strap_q;
    else                              rdata_o = '0;
  end

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_words
    assign words_o[i] = ctl_q[i];
  end
  assign words_o[STRAP_IDX] = strap_q;
endmodule

// File: rtl/pinmux_level_eval.sv
module pinmux_level_eval
  import pinmux_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic [NWORD-1:0][DATA_W-1:0] words_i,
  output logic [NUM_LVL-1:0]           live_o
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_EXPR-1:0] term_hit;
    for (genvar e = 0; e < NUM_EXPR; e++) begin : g_term
      localparam fdesc_t HEAD = desc_at(PIN, l, e, 0);
      logic [NUM_DESC-1:0] cmp_ok;
      for (genvar d = 0; d < NUM_DESC; d++) begin : g_cmp
        localparam fdesc_t DSC = desc_at(PIN, l, e, d);
        logic [1:0] fld;
        assign fld = 2'(words_i[DSC.word] >> DSC.lsb) & DSC.mask;
        assign cmp_ok[d] = !DSC.used || (DSC.neq ? (fld != DSC.val) : (fld == DSC.val));
      end
      assign term_hit[e] = HEAD.used && (&cmp_ok);
    end
    assign live_o[l] = |term_hit;
  end
endmodule

// File: rtl/pinmux_pin_route.sv
module pinmux_pin_route
  import pinmux_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic [NUM_LVL-1:0] live_i,
  input  logic [NSRC-1:0]    src_do_i,
  input  logic [NSRC-1:0]    src_oe_i,
  input  logic               pad_i,
  output logic [NSRC-1:0]    sel_o,
  output logic [NSRC-1:0]    src_di_o,
  output logic               pad_o,
  output logic               pad_oe_o
);
  // Ranked pick: the first live level wins, fallback when none
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (live_i[l] && !taken) begin
        sel_o[l] = 1'b1;
        taken    = 1'b1;
      end
    end
    sel_o[NUM_LVL] = !taken;
  end

  assign pad_o    = |(sel_o & src_do_i);
  assign pad_oe_o = |(sel_o & src_oe_i);

  for (genvar s = 0; s < NSRC; s++) begin : g_ret
    localparam logic IDLE = idle_of(PIN, s);
    assign src_di_o[s] = sel_o[s] ? pad_i : IDLE;
  end
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        strap_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NBYTE-1:0]         be_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_PINS*NSRC-1:0] sel_o,
  input  logic [NUM_PINS*NSRC-1:0] src_do_i,
  input  logic [NUM_PINS*NSRC-1:0] src_oe_i,
  output logic [NUM_PINS*NSRC-1:0] src_di_o,
  input  logic [NUM_PINS-1:0]      pad_i,
  output logic [NUM_PINS-1:0]      pad_o,
  output logic [NUM_PINS-1:0]      pad_oe_o
);
  logic [NWORD-1:0][DATA_W-1:0] words;

  pinmux_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .be_i    (be_i),
    .rdata_o (rdata_o),
    .words_o (words)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_LVL-1:0] live;

    pinmux_level_eval #(.PIN(p)) u_eval (
      .words_i (words),
      .live_o  (live)
    );

    pinmux_pin_route #(.PIN(p)) u_route (
      .live_i   (live),
      .src_do_i (src_do_i[p*NSRC +: NSRC]),
      .src_oe_i (src_oe_i[p*NSRC +: NSRC]),
      .pad_i    (pad_i[p]),
      .sel_o    (sel_o[p*NSRC +: NSRC]),
      .src_di_o (src_di_o[p*NSRC +: NSRC]),
      .pad_o    (pad_o[p]),
      .pad_oe_o (pad_oe_o[p])
    );
  end
endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk
  import pinmux_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [DATA_W-1:0]        rdata_o,
  input logic [NUM_PINS*NSRC-1:0] sel_o,
  input logic [NUM_PINS*NSRC-1:0] src_oe_i,
  input logic [NUM_PINS*NSRC-1:0] src_di_o,
  input logic [NUM_PINS-1:0]      pad_oe_o
);
  localparam logic [ADDR_W-1:0] STRAP_ADDR = ADDR_W'(STRAP_IDX * 4);

  // R2: a write aimed at the strap word leaves its read value unchanged
  a_r2_strap_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == STRAP_ADDR) |=> (addr_i != STRAP_ADDR || $stable(rdata_o)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R3: exactly one owner per pin
    a_r3_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sel_o[p*NSRC +: NSRC]));

    // R10: pad enable follows the selected source in the same cycle
    a_r10_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe_o[p] == |(sel_o[p*NSRC +: NSRC] & src_oe_i[p*NSRC +: NSRC]));

    for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam logic IDLE = idle_of(p, s);
      // R11: unselected sources sit at their idle level
      a_r11_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o[p*NSRC + s] |-> (src_di_o[p*NSRC + s] == IDLE));
    end
  end
endmodule

bind pinmux_top pinmux_chk u_chk (.*);

// File: tb/pinmux_top_tb.sv
`timescale 1ns/1ps
module pinmux_top_tb;
  import pinmux_pkg::*;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic [DATA_W-1:0]        strap_i;
  logic                     wr_en_i;
  logic [ADDR_W-1:0]        addr_i;
  logic [DATA_W-1:0]        wdata_i;
  logic [NBYTE-1:0]         be_i;
  logic [DATA_W-1:0]        rdata_o;
  logic [NUM_PINS*NSRC-1:0] sel_o, src_do_i, src_oe_i, src_di_o;
  logic [NUM_PINS-1:0]      pad_i, pad_o, pad_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] ctl_m [4];
  logic [31:0] strap_m;

  always #10 clk = ~clk;

  pinmux_top u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected winning index per pin (5 = fallback), written from the requirements
  function automatic int exp_idx(int p);
    logic [1:0] md;
    md = ctl_m[2][5:4];
    case (p)
      0: begin
        if (ctl_m[0][3] && ctl_m[1][15]) return ctl_m[2][31] ? 1 : 0;
        return 5;
      end
      1: return (ctl_m[1][12] || strap_m[14]) ? 0 : 5;
      2: begin
        if (md != 0 && ctl_m[3][17]) return 0;
        return ctl_m[3][17] ? 1 : 5;
      end
      3: begin
        if (md == 3 && ctl_m[3][22]) return 0;
        return ctl_m[3][22] ? 1 : 5;
      end
      default: begin
        if (ctl_m[3][0]) return 0;
        return strap_m[6] ? 5 : 1;
      end
    endcase
  endfunction

  function automatic logic idle_exp(int p, int s);
    return (p == 0 && s < 2) || (p == 1 && s == 0) || (p == 3 && s == 1);
  endfunction

  task automatic do_reset(logic [31:0] st);
    rst_n   = 1'b0;
    wr_en_i = 1'b0;
    strap_i = st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    strap_m = st;
    for (int i = 0; i < 4; i++) ctl_m[i] = '0;
  endtask

  task automatic wr(int idx, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en_i = 1'b1;
    addr_i  = 5'(idx * 4);
    wdata_i = d;
    be_i    = be;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (idx < 4)
      for (int b = 0; b < 4; b++) if (be[b]) ctl_m[idx][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic rd_chk(string tag, int idx, logic [31:0] exp);
    addr_i = 5'(idx * 4);
    #1;
    chk(tag, rdata_o, exp);
  endtask

  // Drives random source/pad data, then checks selection, routing and return
  task automatic check_pins(string tag);
    src_do_i = 30'($urandom);
    src_oe_i = 30'($urandom);
    pad_i    = 5'($urandom);
    #1;
    for (int p = 0; p < NUM_PINS; p++) begin
      int e;
      logic [NSRC-1:0] di_exp;
      e = exp_idx(p);
      chk({tag, " R3 R4 sel"}, 32'(sel_o[p*NSRC +: NSRC]), 32'(1 << e));
      chk("R10 pad_o", 32'(pad_o[p]), 32'(src_do_i[p*NSRC + e]));
      chk("R10 pad_oe", 32'(pad_oe_o[p]), 32'(src_oe_i[p*NSRC + e]));
      for (int s = 0; s < NSRC; s++) di_exp[s] = (s == e) ? pad_i[p] : idle_exp(p, s);
      chk("R11 src_di", 32'(src_di_o[p*NSRC +: NSRC]), 32'(di_exp));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    addr_i = '0; wdata_i = '0; be_i = '0;
    src_do_i = '0; src_oe_i = '0; pad_i = '0;

    // R1: reset state and strap capture
    do_reset(32'h0000_4040);
    @(negedge clk);
    for (int i = 0; i < 4; i++) rd_chk("R1 ctl reset", i, 32'h0);
    strap_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd_chk("R1 strap held", 4, 32'h0000_4040);
    check_pins("R1");

    // R2: byte enables, readback, strap read-only, unmapped
    wr(1, 32'hAABB_CCDD, 4'b1111);
    wr(1, 32'h1122_3344, 4'b0101);
    rd_chk("R2 byte enable", 1, 32'hAA22_CC44);
    wr(4, 32'h0, 4'b1111);
    rd_chk("R2 strap ignores write", 4, 32'h0000_4040);
    rd_chk("R2 unmapped", 6, 32'h0);
    wr(1, 32'h0, 4'b1111);

    // R6: strap bit 14 holds pin 1 level 0 regardless of writes
    check_pins("R6 strap");
    wr(1, 32'h0000_1000, 4'b1111);
    check_pins("R6 both");
    wr(1, 32'h0, 4'b1111);
    check_pins("R6 strap only");

    // R5: AND with a required zero on pin 0
    wr(0, 32'h0000_0008, 4'b1111);
    wr(1, 32'h0000_8000, 4'b1111);
    check_pins("R5 level0");
    wr(2, 32'h8000_0000, 4'b1111);
    check_pins("R5 level1");
    wr(0, 32'h0, 4'b1111);
    check_pins("R5 fallback");
    wr(2, 32'h0, 4'b1111);

    // R7 R8: sweep mode field with both per-pin bits set
    wr(3, 32'h0042_0000, 4'b1111);
    for (int m = 0; m < 4; m++) begin
      wr(2, 32'(m << 4), 4'b1111);
      check_pins("R7 R8 mode");
    end
    wr(3, 32'h0, 4'b1111);
    check_pins("R7 R8 no pin bit");

    // R9: non-GPIO fallback with strap[6]=1, GPIO at level 0
    check_pins("R9 fallback");
    wr(3, 32'h0000_0001, 4'b0001);
    check_pins("R9 gpio");

    // Random sweeps over several strap values
    for (int r = 0; r < 4; r++) begin
      do_reset($urandom);
      check_pins("R1 R9 strap");
      for (int k = 0; k < 150; k++) begin
        wr($urandom_range(0, 4), $urandom, 4'($urandom));
        check_pins("R4 random");
      end
      rd_chk("R2 random readback", 2, ctl_m[2]);
    end
    summary();
  end
endmodule